// File: doc/BRIEF.md
# SPI Controller Shift Engine

This block is a full-duplex SPI controller-mode shift engine. A single clock generator makes the serial clock. It counts in two byte-wide fields: the low byte of a 16-bit compare word sets the half-period divider, and the high byte sets the number of counted clock edges in each word. One shift register drives the data-out pin and a second one captures the data-in pin, both in step with that clock. Clock polarity, clock phase, word size (8, 16 or 32 bits) and bit order are configuration inputs.

Software or a DMA-side agent loads one transmit word through a valid/ready port. That word goes into a one-word buffer, and the engine starts as soon as the buffer is full. When the word has shifted, the received word is latched and a receive-full flag is raised. A pulse on the acknowledge input clears the flag. If the buffer is refilled while a word is in flight, the next word follows directly after the stop half-period, with no idle gap.

The clock generator is a three-state machine. `T_IDLE` waits for a full buffer. On that condition it accepts the word (transition *accept*) and moves to `T_RUN`. `T_RUN` toggles the clock once every divider+1 cycles. After its last edge (transition *last edge*) it moves to `T_STOP`, which holds the clock at idle for one half-period. At the end of that half-period, `T_STOP` either takes the next buffered word back into `T_RUN` (transition *chain*) or returns to `T_IDLE` (transition *drain*).

Top module: `spi_ctl_engine`

## Requirements
- R1: Each serial clock half-period lasts exactly (cfg_cmp[7:0] + 1) clock cycles. The half-period before the first edge and the stop half-period after the last edge have the same length.
- R2: With cfg_cmp[15:8] = 2N−1, one word produces exactly 2N serial clock transitions. These are the counted edges plus a closing edge that returns the clock to its idle level.
- R3: A word accepted while tx_ready is high is held in a one-word buffer, and tx_ready is low while the buffer is full. From idle, the engine takes the word one cycle after it is loaded, and tx_ready rises again.
- R4: With cfg_cpha = 0, data-out shows the first bit before the first leading clock edge and changes only on trailing edges. Data-in is sampled on leading edges.
- R5: With cfg_cpha = 1, data-out is low until the first leading edge. It then changes on leading edges and returns low (stop level) after the word. Data-in is sampled on trailing edges.
- R6: The serial clock pin idles at the level of cfg_cpol. cfg_cpol = 1 inverts the pin and nothing else.
- R7: cfg_size codes: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits. Code 3 is ignored and the previous size is kept. The size is taken only while the engine is idle.
- R8: cfg_lsb = 0 sends and receives the word MSB first. cfg_lsb = 1 sends and receives it LSB first. The received word is right-aligned in rx_data with zeros above bit N−1.
- R9: On the closing edge of a word, rx_data is updated and rx_full is raised. rx_ack clears rx_full.
- R10: A word buffered during a transfer starts straight after the stop half-period. The first edge of the new word comes 2 × (divider + 1) cycles after the last edge of the previous word.
- R11: After reset: tx_ready = 1, rx_full = 0, rx_data = 0, data-out = 0, the clock generator idle and the word size 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cmp | input | 16 | [7:0] half-period divider, [15:8] counted edges per word (2N−1) |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_size | input | 2 | Word size code (0: 8, 1: 16, 2: 32, 3: ignored) |
| cfg_lsb | input | 1 | 1: LSB first |
| tx_data | input | 32 | Transmit word |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_data | output | 32 | Last received word, right-aligned |
| rx_full | output | 1 | A received word is waiting |
| rx_ack | input | 1 | Clears rx_full |
| sck | output | 1 | Serial clock pin |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench runs single words in all four polarity/phase combinations. Each combination uses a different size, bit order and divider, so that leading-edge versus trailing-edge sampling and MSB-first versus LSB-first both show up as wrong bit streams on the pins. The divider runs from 0 to 3, which separates an off-by-one in the half-period count from a correct one. An illegal size code after a 16-bit setting shows whether the size register kept its old value. A second word loaded while the first is in flight shows whether the chain transition leaves exactly one stop half-period and one start half-period between the words.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_RUN  = 2'd1,
        T_STOP = 2'd2
    } tmr_state_t;

    localparam logic [1:0] WS_8   = 2'd0;
    localparam logic [1:0] WS_16  = 2'd1;
    localparam logic [1:0] WS_32  = 2'd2;
    localparam logic [1:0] WS_BAD = 2'd3;

    function automatic int unsigned ws_bits(input logic [1:0] code);
        case (code)
            WS_16:   return 16;
            WS_32:   return 32;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/spi_eng_baud.sv
module spi_eng_baud
    import spi_eng_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [DIV_W-1:0] div,
    input  logic [CNT_W-1:0] last_edge,
    output logic             accept,
    output logic             busy,
    output logic             sck_o,
    output logic             rise_ev,
    output logic             fall_ev,
    output logic             word_end
);

    tmr_state_t       state, nxt;
    logic [DIV_W-1:0] div_q, div_cnt;
    logic [CNT_W-1:0] last_q, edge_cnt;
    logic             sck_q;
    logic             tc;

    assign tc = (div_cnt == div_q);

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            T_IDLE: if (req) nxt = T_RUN;
            T_RUN:  if (tc && (edge_cnt == last_q)) nxt = T_STOP;
            T_STOP: if (tc) nxt = req ? T_RUN : T_IDLE;
            default: nxt = T_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= T_IDLE;
        else        state <= nxt;
    end

    // outputs
    always_comb begin
        accept   = 1'b0;
        rise_ev  = 1'b0;
        fall_ev  = 1'b0;
        word_end = 1'b0;
        unique case (state)
            T_IDLE: accept = req;
            T_RUN: begin
                rise_ev  = tc && !sck_q;
                fall_ev  = tc &&  sck_q;
                word_end = tc && (edge_cnt == last_q);
            end
            T_STOP: accept = tc && req;
            default: ;
        endcase
    end

    assign busy  = (state != T_IDLE);
    assign sck_o = sck_q;

    // counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q    <= '0;
            last_q   <= '0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            sck_q    <= 1'b0;
        end else if (accept) begin
            div_q    <= div;
            last_q   <= last_edge;
            div_cnt  <= '0;
            edge_cnt <= '0;
            sck_q    <= 1'b0;
        end else if (state == T_RUN) begin
            if (tc) begin
                div_cnt  <= '0;
                sck_q    <= ~sck_q;
                edge_cnt <= edge_cnt + 1'b1;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end else if (state == T_STOP) begin
            div_cnt <= tc ? '0 : div_cnt + 1'b1;
        end else begin
            div_cnt <= '0;
        end
    end

    assert_div_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state != T_IDLE) |-> (div_cnt <= div_q));

    assert_edge_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_RUN) |-> (edge_cnt <= last_q));

    assert_stop_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |=> (state == T_STOP));

endmodule

// File: rtl/spi_eng_txsh.sv
module spi_eng_txsh #(
    parameter int DW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [DW-1:0]            load_data,
    input  logic                     cpha,
    input  logic                     lsb,
    input  logic [$clog2(DW):0]      nbits,
    input  logic                     rise_ev,
    input  logic                     fall_ev,
    input  logic                     word_end,
    output logic                     mosi
);

    localparam int NB_W = $clog2(DW) + 1;
    localparam int IX_W = $clog2(DW);

    logic [DW-1:0]   sh;
    logic            live, cpha_q, lsb_q;
    logic [NB_W-1:0] n_q;
    logic [IX_W-1:0] idx;
    logic            shift_ev, cur_bit;

    assign idx      = IX_W'(n_q - 1'b1);
    assign shift_ev = cpha_q ? rise_ev : fall_ev;
    assign cur_bit  = lsb_q ? sh[0] : sh[idx];
    assign mosi     = live & cur_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            live   <= 1'b0;
            cpha_q <= 1'b0;
            lsb_q  <= 1'b0;
            n_q    <= NB_W'(8);
        end else if (load) begin
            sh     <= load_data;
            live   <= !cpha;
            cpha_q <= cpha;
            lsb_q  <= lsb;
            n_q    <= nbits;
        end else if (word_end && cpha_q) begin
            live <= 1'b0;
        end else if (shift_ev) begin
            if (!live) live <= 1'b1;
            else       sh   <= lsb_q ? (sh >> 1) : (sh << 1);
        end
    end

    assert_stop_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_end && cpha_q) |=> !mosi);

    assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpha_q && !fall_ev && !load && $past(!load)) |=> $stable(mosi));

endmodule

// File: rtl/spi_eng_rxsh.sv
module spi_eng_rxsh #(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 cpha,
    input  logic                 lsb,
    input  logic [$clog2(DW):0]  nbits,
    input  logic                 rise_ev,
    input  logic                 fall_ev,
    input  logic                 word_end,
    input  logic                 miso,
    output logic [DW-1:0]        word_o
);

    localparam int NB_W = $clog2(DW) + 1;

    logic [DW-1:0]   sh, nxt, aligned, mask;
    logic            cpha_q, lsb_q, sample;
    logic [NB_W-1:0] n_q, cnt;

    assign sample  = cpha_q ? fall_ev : rise_ev;
    assign nxt     = !sample ? sh :
                     (lsb_q ? {miso, sh[DW-1:1]} : {sh[DW-2:0], miso});
    assign aligned = lsb_q ? (nxt >> (NB_W'(DW) - n_q)) : nxt;
    assign mask    = ~({DW{1'b1}} << n_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            cpha_q <= 1'b0;
            lsb_q  <= 1'b0;
            n_q    <= NB_W'(8);
            word_o <= '0;
        end else if (load) begin
            sh     <= '0;
            cnt    <= '0;
            cpha_q <= cpha;
            lsb_q  <= lsb;
            n_q    <= nbits;
        end else begin
            sh <= nxt;
            if (sample) cnt <= cnt + 1'b1;
            if (word_end) word_o <= aligned & mask;
        end
    end

    assert_sample_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_end |-> ((cnt + NB_W'(sample)) == n_q));

endmodule

// File: rtl/spi_ctl_engine.sv
module spi_ctl_engine
    import spi_eng_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DIV_W = 8,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DIV_W+CNT_W-1:0] cfg_cmp,
    input  logic                   cfg_cpol,
    input  logic                   cfg_cpha,
    input  logic [1:0]             cfg_size,
    input  logic                   cfg_lsb,
    input  logic [DW-1:0]          tx_data,
    input  logic                   tx_valid,
    output logic                   tx_ready,
    output logic [DW-1:0]          rx_data,
    output logic                   rx_full,
    input  logic                   rx_ack,
    output logic                   sck,
    output logic                   mosi,
    input  logic                   miso
);

    localparam int NB_W = $clog2(DW) + 1;

    logic [DW-1:0]   tx_buf;
    logic            tx_full;
    logic [1:0]      size_q;
    logic [NB_W-1:0] nbits;
    logic            accept, busy, sck_int, rise_ev, fall_ev, word_end;

    assign nbits    = NB_W'(ws_bits(size_q));
    assign tx_ready = !tx_full;
    assign sck      = sck_int ^ cfg_cpol;

    // word size register: illegal code keeps the old value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            size_q <= WS_8;
        else if (!busy && cfg_size != WS_BAD)  size_q <= cfg_size;
    end

    // one-word transmit buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf  <= '0;
            tx_full <= 1'b0;
        end else if (accept) begin
            tx_full <= 1'b0;
        end else if (tx_valid && !tx_full) begin
            tx_buf  <= tx_data;
            tx_full <= 1'b1;
        end
    end

    // receive flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_full <= 1'b0;
        else if (word_end) rx_full <= 1'b1;
        else if (rx_ack)   rx_full <= 1'b0;
    end

    spi_eng_baud #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (tx_full),
        .div       (cfg_cmp[DIV_W-1:0]),
        .last_edge (cfg_cmp[DIV_W+CNT_W-1:DIV_W]),
        .accept    (accept),
        .busy      (busy),
        .sck_o     (sck_int),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .word_end  (word_end)
    );

    spi_eng_txsh #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_data (tx_buf),
        .cpha      (cfg_cpha),
        .lsb       (cfg_lsb),
        .nbits     (nbits),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .word_end  (word_end),
        .mosi      (mosi)
    );

    spi_eng_rxsh #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .cpha     (cfg_cpha),
        .lsb      (cfg_lsb),
        .nbits    (nbits),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev),
        .word_end (word_end),
        .miso     (miso),
        .word_o   (rx_data)
    );

    assert_ready_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_ready) |-> $past(tx_valid));

    assert_full_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(word_end));

    assert_size_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        size_q != WS_BAD);

    assert_size_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(size_q));

endmodule

// File: tb/tb_spi_ctl_engine.sv
module tb_spi_ctl_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_cmp = 16'h0F01;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;
    logic [1:0]  cfg_size = 2'd0;
    logic [31:0] tx_data = '0;
    logic        tx_valid = 1'b0, rx_ack = 1'b0;
    logic        tx_ready, rx_full, sck, mosi;
    logic [31:0] rx_data;
    logic        miso_r = 1'b0;

    always #5 clk = ~clk;

    spi_ctl_engine dut (
        .clk(clk), .rst_n(rst_n), .cfg_cmp(cfg_cmp), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_size(cfg_size), .cfg_lsb(cfg_lsb),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_full(rx_full), .rx_ack(rx_ack),
        .sck(sck), .mosi(mosi), .miso(miso_r)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bench-side peripheral model, clocked on the falling system edge
    bit   s_on = 0;
    logic s_cpol = 0, s_cpha = 0, s_sck_prev = 0, s_mosi_prev = 0, s_lead;
    logic s_in [64];
    logic s_out[64];
    int   s_nin, s_nout, s_edges, s_gap, s_min, s_max;

    always @(negedge clk) begin
        if (s_on) begin
            s_gap++;
            if (sck !== s_sck_prev) begin
                s_lead = (sck != s_cpol);
                if (s_edges > 0) begin
                    if (s_gap < s_min) s_min = s_gap;
                    if (s_gap > s_max) s_max = s_gap;
                end
                s_gap = 0;
                s_edges++;
                if (s_lead ^ s_cpha) begin
                    if (s_nin < 64) s_in[s_nin] = s_mosi_prev;
                    s_nin++;
                end else begin
                    if (s_nout < 64) miso_r = s_out[s_nout];
                    s_nout++;
                end
            end
        end
        s_sck_prev  = sck;
        s_mosi_prev = mosi;
    end

    function automatic logic [31:0] msk(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    task automatic slave_arm(input logic cpol, input logic cpha, input int n,
                             input logic lsb, input logic [31:0] w0, input logic [31:0] w1);
        s_cpol = cpol; s_cpha = cpha;
        for (int k = 0; k < n; k++) begin
            s_out[k]     = lsb ? w0[k] : w0[n-1-k];
            s_out[n + k] = lsb ? w1[k] : w1[n-1-k];
        end
        s_nin = 0; s_edges = 0; s_gap = 0; s_min = 1000; s_max = 0;
        if (!cpha) begin miso_r = s_out[0]; s_nout = 1; end
        else       begin s_nout = 0; end
        s_sck_prev = sck; s_mosi_prev = mosi;
        s_on = 1;
    endtask

    task automatic set_cfg(input logic cpol, input logic cpha, input logic [1:0] code,
                           input logic lsb, input int n, input int div);
        @(negedge clk);
        cfg_cpol = cpol; cfg_cpha = cpha; cfg_size = code; cfg_lsb = lsb;
        cfg_cmp = {8'(2*n - 1), 8'(div)};
        @(negedge clk);
    endtask

    task automatic wait_full(input string req);
        int t = 0;
        while (!rx_full && t < 5000) begin @(negedge clk); t++; end
        chk(rx_full == 1'b1, req, "rx_full raised", rx_full, 1);
    endtask

    task automatic check_stream(input string req, input int base, input int n,
                                input logic lsb, input logic [31:0] w);
        logic [31:0] got = '0;
        logic [31:0] exp = '0;
        for (int k = 0; k < n; k++) begin
            got[k] = s_in[base + k];
            exp[k] = lsb ? w[k] : w[n-1-k];
        end
        chk(got == exp, req, "data-out bit stream", got, exp);
    endtask

    // one word in a given mode
    task automatic run_word(input logic cpol, input logic cpha, input logic [1:0] code,
                            input logic lsb, input int n, input int div,
                            input logic [31:0] txw, input logic [31:0] slw, input string req);
        set_cfg(cpol, cpha, code, lsb, n, div);
        chk(sck == cpol, "R6", "idle clock level", sck, cpol);
        slave_arm(cpol, cpha, n, lsb, slw, 32'h0);
        tx_data = txw; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R3", "ready low while buffered", tx_ready, 0);
        @(negedge clk);
        chk(tx_ready == 1'b1, "R3", "ready back after take", tx_ready, 1);
        if (cpha) chk(mosi == 1'b0, "R5", "data-out low before first edge", mosi, 0);
        wait_full("R9");
        repeat (div + 3) @(negedge clk);
        s_on = 0;
        check_stream(req, 0, n, lsb, txw);
        chk(s_nin == n, "R7", "bits sampled per word", s_nin, n);
        chk(s_edges == 2 * n, "R2", "clock transitions per word", s_edges, 2 * n);
        chk(s_min == div + 1 && s_max == div + 1, "R1", "half-period cycles",
            s_max * 1000 + s_min, (div + 1) * 1001);
        chk(rx_data == (slw & msk(n)), req, "received word", rx_data, slw & msk(n));
        chk(sck == cpol, "R6", "clock back at idle level", sck, cpol);
        if (cpha) chk(mosi == 1'b0, "R5", "data-out at stop level", mosi, 0);
        rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
        chk(rx_full == 1'b0, "R9", "ack clears rx_full", rx_full, 0);
    endtask

    task automatic t_reset;
        chk(tx_ready == 1'b1, "R11", "tx_ready after reset", tx_ready, 1);
        chk(rx_full == 1'b0, "R11", "rx_full after reset", rx_full, 0);
        chk(rx_data == 32'h0, "R11", "rx_data after reset", rx_data, 0);
        chk(mosi == 1'b0 && sck == 1'b0, "R11", "pins after reset", {sck, mosi}, 0);
    endtask

    task automatic t_modes;
        run_word(1'b0, 1'b0, 2'd0, 1'b0,  8, 1, 32'h0000_00A5, 32'h0000_003C, "R4"); // R8 MSB
        run_word(1'b1, 1'b1, 2'd1, 1'b1, 16, 2, 32'h0000_C3E1, 32'h0000_8421, "R5"); // R8 LSB
        run_word(1'b0, 1'b1, 2'd2, 1'b0, 32, 0, 32'hDEAD_BEEF, 32'h1357_9BDF, "R8");
        run_word(1'b1, 1'b0, 2'd0, 1'b1,  8, 3, 32'h0000_0096, 32'h0000_00F1, "R8");
    endtask

    task automatic t_bad_size;
        run_word(1'b0, 1'b0, 2'd1, 1'b0, 16, 0, 32'h0000_5AA5, 32'h0000_1234, "R7");
        // code 3 must leave 16 bits in place
        run_word(1'b0, 1'b0, 2'd3, 1'b0, 16, 0, 32'h0000_F00D, 32'h0000_ABCD, "R7");
    endtask

    task automatic t_chain;
        logic [31:0] a = 32'h0000_00C9, b = 32'h0000_0036;
        logic [31:0] sa = 32'h0000_0055, sb = 32'h0000_00E7;
        int div = 1;
        set_cfg(1'b0, 1'b0, 2'd0, 1'b0, 8, div);
        slave_arm(1'b0, 1'b0, 8, 1'b0, sa, sb);
        tx_data = a; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
        while (!tx_ready) @(negedge clk);
        tx_data = b; tx_valid = 1'b1; @(negedge clk); tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R3", "second word held in buffer", tx_ready, 0);
        wait_full("R10");
        chk(rx_data == sa, "R10", "first chained word", rx_data, sa);
        rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
        wait_full("R10");
        repeat (div + 3) @(negedge clk);
        s_on = 0;
        chk(rx_data == sb, "R10", "second chained word", rx_data, sb);
        chk(s_edges == 32, "R10", "transitions for two words", s_edges, 32);
        chk(s_max == 2 * (div + 1), "R10", "gap between words", s_max, 2 * (div + 1));
        check_stream("R10", 0, 8, 1'b0, a);
        check_stream("R10", 8, 8, 1'b0, b);
        rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_bad_size();
        t_chain();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule